// File: doc/BRIEF.md
# Chunked SPI Write-Data Receiver

This block takes in the data phase that follows an accepted block-write command on an SPI slave. A command decoder pulses `start` with the destination address, the total byte count and whether trailers are in use. The deserialised byte stream then arrives on `rx_valid`/`rx_byte`. The transfer is cut into packets. Each packet is a header byte, a payload of up to `PKT_MAX` bytes, and, when trailers are in use, two trailer bytes. Payload bytes go straight to a memory-style write port whose address counts up from the command address. Nothing is sent back to the host during this phase.

The header byte is `0xF0` ORed with a 2-bit position code: 1 for the first of several packets, 2 for a middle packet, 3 for the final or only packet. The receiver works out which code must come next from its remaining count. Any other header is a framing error, and the error ends the transfer.

Controller states:
- `ST_IDLE`: waits for `start`.
- `ST_HDR`: expects a header.
- `ST_DATA`: stores payload.
- `ST_TRL0`: skips the first trailer byte.
- `ST_TRL1`: skips the second trailer byte.
- `ST_FIN`: one-cycle completion.
- `ST_FAULT`: one-cycle framing error.

Transitions:
- IDLE→HDR: start with an accepted count.
- IDLE→FAULT: start with a count that is too short.
- HDR→DATA: good header.
- HDR→FAULT: bad header.
- DATA→TRL0: packet end with trailers on.
- DATA→HDR: packet end with bytes left and trailers off.
- DATA→FIN: last byte with trailers off.
- TRL0→TRL1: first trailer byte taken.
- TRL1→HDR: trailer done with bytes left.
- TRL1→FIN: trailer done with nothing left.
- FIN→IDLE and FAULT→IDLE: unconditional.

Top module: `dblk_rx`

## Requirements
- R1: After reset, `busy`, `done`, `frame_err` and `wr_en` are all 0.
- R2: A `start` in idle with `total_len` of at least 5 captures `base_addr`, `total_len` and `crc_en` and raises `busy` on the next cycle. A `start` with `total_len` below 5 gives a one-cycle `frame_err` pulse, leaves `busy` low and writes nothing.
- R3: A header is valid only if bits 7:4 are 0xF, bits 3:2 are 0 and bits 1:0 hold the expected code. The expected code is 3 when the remaining count is at most `PKT_MAX`. Otherwise it is 1 for the first packet and 2 for any later packet.
- R4: Each packet's payload length is the smaller of the remaining count and `PKT_MAX`.
- R5: In the same cycle that a payload byte is presented with `rx_valid`, `wr_en` is 1, `wr_data` equals that byte and `wr_addr` equals the start address plus the byte's index in the transfer. `wr_en` is 0 at all other times.
- R6: With the captured `crc_en` = 1, two trailer bytes follow every payload and are consumed without being written. With `crc_en` = 0 the next header follows the payload directly. Changing `crc_en` after `start` has no effect.
- R7: A header that fails R3 gives a one-cycle `frame_err` pulse and a return to idle (`busy` = 0). No byte after it is written.
- R8: `done` pulses for exactly one cycle, in the cycle after the last byte of the final packet is taken (the final payload byte, or the second trailer byte), and `busy` is 0 in that cycle.
- R9: `start` is ignored while a transfer is in progress: address and count are unchanged.
- R10: Cycles with `rx_valid` = 0 change no state and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command accepted; begin data phase |
| base_addr | input | ADDR_W | First write address |
| total_len | input | CNT_W | Total payload bytes in the transfer |
| crc_en | input | 1 | Two trailer bytes per packet when 1 |
| rx_valid | input | 1 | `rx_byte` holds a new byte |
| rx_byte | input | 8 | Byte from the deserialiser |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| frame_err | output | 1 | One-cycle framing-error pulse |

## Verification
The hardest condition to reach is the switch of the expected position code: first, then middle, then final. It depends on the remaining count crossing a multiple of the packet size, and on whether the first packet has already passed. The bench shrinks the packet size to 8 and sweeps every transfer length from 5 to 20, with and without trailers and with idle gaps. Every length therefore lands on, just under or just over one and two packet boundaries. Wrong codes are then injected at the first, middle and final positions of such transfers to hit each rejection path.

// File: rtl/dblk_pkg.sv
package dblk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_TRL0,
        ST_TRL1,
        ST_FIN,
        ST_FAULT
    } rx_state_e;

    localparam logic [3:0] HDR_TAG   = 4'hF;
    localparam logic [1:0] ORD_FIRST = 2'd1;
    localparam logic [1:0] ORD_MID   = 2'd2;
    localparam logic [1:0] ORD_LAST  = 2'd3;
endpackage

// File: rtl/dblk_hdr_chk.sv
module dblk_hdr_chk #(
    parameter int PKT_MAX = 8192,
    parameter int CNT_W   = 24
) (
    input  logic [7:0]       hdr,
    input  logic [CNT_W-1:0] rem,
    input  logic             first,
    output logic [1:0]       exp_ord,
    output logic             hdr_ok
);
    import dblk_pkg::*;

    logic is_final;

    always_comb begin
        is_final = (rem <= CNT_W'(PKT_MAX));
        if (is_final) begin
            exp_ord = ORD_LAST;
        end else if (first) begin
            exp_ord = ORD_FIRST;
        end else begin
            exp_ord = ORD_MID;
        end
        hdr_ok = (hdr[7:4] == HDR_TAG) && (hdr[3:2] == 2'b00) && (hdr[1:0] == exp_ord);
    end
endmodule

// File: rtl/dblk_track.sv
module dblk_track #(
    parameter int PKT_MAX = 8192,
    parameter int ADDR_W  = 24,
    parameter int CNT_W   = 24,
    localparam int PKT_W  = $clog2(PKT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  len,
    input  logic              pkt_open,
    input  logic              take,
    output logic [CNT_W-1:0]  rem,
    output logic [PKT_W-1:0]  pkt_left,
    output logic [ADDR_W-1:0] addr,
    output logic              first
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            pkt_left <= '0;
            addr     <= '0;
            first    <= 1'b0;
        end else if (load) begin
            rem      <= len;
            pkt_left <= '0;
            addr     <= base;
            first    <= 1'b1;
        end else if (pkt_open) begin
            first    <= 1'b0;
            if (rem > CNT_W'(PKT_MAX)) begin
                pkt_left <= PKT_W'(PKT_MAX);
            end else begin
                pkt_left <= PKT_W'(rem);
            end
        end else if (take) begin
            rem      <= rem - 1'b1;
            pkt_left <= pkt_left - 1'b1;
            addr     <= addr + 1'b1;
        end
    end

    AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_left <= PKT_W'(PKT_MAX)); // R4
    AST_TAKE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (rem != '0) && (pkt_left != '0)); // R4
endmodule

// File: rtl/dblk_rx.sv
module dblk_rx #(
    parameter int PKT_MAX = 8192,
    parameter int ADDR_W  = 24,
    parameter int CNT_W   = 24,
    parameter int MIN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  total_len,
    input  logic              crc_en,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic              frame_err
);
    import dblk_pkg::*;

    localparam int PKT_W = $clog2(PKT_MAX + 1);

    rx_state_e         state, state_nx;
    logic              crc_q;
    logic              accept, reject, pkt_open, take;
    logic              hdr_ok, first;
    logic [1:0]        exp_ord;
    logic [CNT_W-1:0]  rem;
    logic [PKT_W-1:0]  pkt_left;
    logic [ADDR_W-1:0] addr;
    logic              pkt_end;

    assign accept   = (state == ST_IDLE) && start && (total_len >= CNT_W'(MIN_LEN));
    assign reject   = (state == ST_IDLE) && start && (total_len <  CNT_W'(MIN_LEN));
    assign pkt_open = (state == ST_HDR) && rx_valid && hdr_ok;
    assign take     = (state == ST_DATA) && rx_valid;
    assign pkt_end  = (pkt_left == PKT_W'(1));

    dblk_hdr_chk #(.PKT_MAX(PKT_MAX), .CNT_W(CNT_W)) u_hdr (
        .hdr     (rx_byte),
        .rem     (rem),
        .first   (first),
        .exp_ord (exp_ord),
        .hdr_ok  (hdr_ok)
    );

    dblk_track #(.PKT_MAX(PKT_MAX), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .base     (base_addr),
        .len      (total_len),
        .pkt_open (pkt_open),
        .take     (take),
        .rem      (rem),
        .pkt_left (pkt_left),
        .addr     (addr),
        .first    (first)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept)      state_nx = ST_HDR;
                else if (reject) state_nx = ST_FAULT;
            end
            ST_HDR: begin
                if (rx_valid) state_nx = hdr_ok ? ST_DATA : ST_FAULT;
            end
            ST_DATA: begin
                if (rx_valid && pkt_end) begin
                    if (crc_q)                      state_nx = ST_TRL0;
                    else if (rem == CNT_W'(1))      state_nx = ST_FIN;
                    else                            state_nx = ST_HDR;
                end
            end
            ST_TRL0: begin
                if (rx_valid) state_nx = ST_TRL1;
            end
            ST_TRL1: begin
                if (rx_valid) state_nx = (rem == '0) ? ST_FIN : ST_HDR;
            end
            ST_FIN:   state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            crc_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) crc_q <= crc_en;
        end
    end

    always_comb begin
        wr_en     = take;
        wr_addr   = addr;
        wr_data   = rx_byte;
        busy      = (state == ST_HDR) || (state == ST_DATA) ||
                    (state == ST_TRL0) || (state == ST_TRL1);
        done      = (state == ST_FIN);
        frame_err = (state == ST_FAULT);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem == '0)); // R8
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_addr == $past(wr_addr) + 1'b1)); // R5
    AST_EXCL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, frame_err, wr_en})); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rx_valid) |=> $stable(rem) && $stable(wr_addr)); // R10
    AST_BAD_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && rx_valid && rx_byte[7:4] != HDR_TAG) |=> frame_err); // R3
endmodule

// File: tb/sim_dblk_rx.sv
module sim_dblk_rx;
    localparam int PKT = 8;
    localparam int AW  = 16;
    localparam int CW  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] total_len = '0;
    logic          crc_en = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          wr_en, busy, done, frame_err;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int exp_base = 0;
    int wr_idx = 0;
    int seed = 0;
    bit expect_wr = 1'b0;
    int err_seen = 0;

    always #5 clk = ~clk;

    dblk_rx #(.PKT_MAX(PKT), .ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .total_len(total_len), .crc_en(crc_en), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .frame_err(frame_err)
    );

    function automatic logic [7:0] pat(int s, int i);
        return 8'((s + i * 13) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // R5 write monitor: address, data and permission of every write
    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            chk(expect_wr, "R5 R7 unexpected write", 1, 0);
            chk(wr_addr == AW'(exp_base + wr_idx), "R5 wr_addr", int'(wr_addr), exp_base + wr_idx);
            chk(wr_data == pat(seed, wr_idx), "R5 wr_data", int'(wr_data), int'(pat(seed, wr_idx)));
            wr_idx++;
        end
        if (rst_n && frame_err) err_seen++;
    end

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h3C;
    endtask

    task automatic idle_cyc();
        @(negedge clk);
    endtask

    task automatic do_start(input int base, input int len, input bit c);
        start = 1'b1;
        base_addr = AW'(base);
        total_len = CW'(len);
        crc_en = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_xfer(input int len, input bit c, input int base, input int s,
                            input bit gaps, input bit poke);
        int rem;
        int idx;
        bit first;
        int e0;
        e0 = err_seen;
        exp_base = base;
        seed = s;
        wr_idx = 0;
        expect_wr = 1'b1;
        do_start(base, len, c);
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        crc_en = ~c; // R6: late change must not matter
        rem = len;
        idx = 0;
        first = 1'b1;
        while (rem > 0) begin
            int n;
            logic [1:0] ord;
            n = (rem > PKT) ? PKT : rem;
            ord = (rem <= PKT) ? 2'd3 : (first ? 2'd1 : 2'd2);
            send(8'hF0 | 8'(ord)); // R3 header
            if (poke && first) begin
                do_start(base + 16'h4000, 30, ~c); // R9
            end
            first = 1'b0;
            for (int k = 0; k < n; k++) begin
                if (gaps && (idx % 3 == 0)) idle_cyc(); // R10
                send(pat(s, idx));
                idx++;
            end
            rem -= n;
            if (c) begin
                if (gaps) idle_cyc();
                send(8'hA5); // R6 trailer, not written
                send(8'h5A);
            end
        end
        chk(done == 1'b1, "R8 done after final byte", int'(done), 1);
        chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
        expect_wr = 1'b0;
        idle_cyc();
        chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
        chk(wr_idx == len, "R4 R6 byte count", wr_idx, len);
        chk(err_seen == e0, "R3 no framing error", err_seen - e0, 0);
    endtask

    task automatic expect_fault(input string tag);
        chk(frame_err == 1'b1, tag, int'(frame_err), 1);
        chk(busy == 1'b0, "R7 idle after error", int'(busy), 0);
        expect_wr = 1'b0;
        send(8'h77); // R7: trailing byte not written
        chk(frame_err == 1'b0, "R7 error single cycle", int'(frame_err), 0);
        chk(busy == 1'b0, "R7 stays idle", int'(busy), 0);
    endtask

    task automatic bad_case(input int len, input int good_pkts, input logic [7:0] bad_hdr,
                            input string tag);
        int idx;
        exp_base = 16'h0200;
        seed = len;
        wr_idx = 0;
        expect_wr = 1'b1;
        do_start(16'h0200, len, 1'b0);
        idx = 0;
        for (int p = 0; p < good_pkts; p++) begin
            send((p == 0) ? 8'hF1 : 8'hF2);
            for (int k = 0; k < PKT; k++) begin
                send(pat(len, idx));
                idx++;
            end
        end
        send(bad_hdr);
        expect_fault(tag);
        chk(wr_idx == idx, "R7 writes before error only", wr_idx, idx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !frame_err && !wr_en, "R1 reset state",
            int'({busy, done, frame_err, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !frame_err && !wr_en, "R1 idle after reset",
            int'({busy, done, frame_err, wr_en}), 0);

        // R10: bytes while idle are not written
        send(8'hF3);
        chk(busy == 1'b0, "R10 idle bytes ignored", int'(busy), 0);

        // R2: too-short transfers
        do_start(16'h0100, 4, 1'b0);
        expect_fault("R2 len 4 rejected");
        do_start(16'h0100, 0, 1'b1);
        expect_fault("R2 len 0 rejected");

        // R3 R4 R6: sweep lengths around packet boundaries
        for (int c = 0; c < 2; c++) begin
            for (int len = 5; len <= 20; len++) begin
                run_xfer(len, c[0], 16'h1000 + len * 64 + c * 16'h0800, len * 3 + c, len[0], 1'b0);
            end
        end

        // R9: start while busy
        run_xfer(12, 1'b0, 16'h2200, 99, 1'b0, 1'b1);
        run_xfer(17, 1'b1, 16'h2300, 41, 1'b1, 1'b1);

        // R3 R7: header rejections
        bad_case(20, 0, 8'hE1, "R3 bad tag nibble");
        bad_case(20, 0, 8'hF3, "R3 final code on first of several");
        bad_case(20, 0, 8'hF5, "R3 nonzero bits 3:2");
        bad_case(20, 0, 8'hF2, "R3 middle code on first");
        bad_case(20, 1, 8'hF1, "R3 first code on middle");
        bad_case(20, 1, 8'hF3, "R3 final code on middle");
        bad_case(12, 1, 8'hF2, "R3 middle code on final");
        bad_case(7, 0, 8'hF1, "R3 first code on only");

        // recovery after errors
        run_xfer(9, 1'b1, 16'h3000, 7, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule